// File: doc/BRIEF.md
# USB IN Endpoint Response Selector

This block chooses the answer a USB device gives to each IN token on one endpoint. The endpoint draws its data from a circular buffer. A local processor fills that buffer and then publishes its new write position through a write-offset register. The block owns the read position and moves it forward only after the host acknowledges a data packet.

When the buffer holds at least one maximum-size packet, the block sends a full packet. When it holds less, it sends NAK. There is one exception, which applies only when the consecutive-NAK counter is enabled. Once that counter has gone above a programmed 4-bit limit, the block sends whatever data is present as a short packet, and that packet may have zero length. This lets a partial transfer finish.

If the host times out, the next token gets the same length again and the read position does not move. The block also flags the processor when the buffer is full, which is when the write position sits one slot behind the read position.

Top module: `usb_in_nak_responder`

## Requirements
- R1: After reset, the read and write positions are 0, `rsp_valid` is 0, `buf_full` is 0, and the NAK counter is 0.
- R2: `rsp_valid` pulses for one cycle, one clock after a cycle with `tok_in`=1. If no retry is pending and occupancy ((write − read) mod depth) is at least the maximum packet size, the response is data (`rsp_data`=1) with `rsp_len` equal to the maximum packet size.
- R3: While the counter enable bit is 0, every token that finds occupancy below the maximum packet size gets NAK (`rsp_data`=0), however many tokens arrive.
- R4: While the counter enable bit is 1 and occupancy is below the maximum packet size, each NAK raises the counter by one. A token that finds the counter above the limit gets a short packet whose length is the occupancy. With limit L, that happens on token L+2.
- R5: An ACK of a data packet clears the counter, so the next short packet again needs L+1 NAKs first.
- R6: An ACK of a data packet advances the read position by its length, modulo the depth. A timeout leaves the read position unchanged, and the next token resends the same length even if more data has arrived.
- R7: A short packet has length 0 when the buffer is empty and the counter is above the limit. Its ACK leaves the read position unchanged.
- R8: `buf_full` is 1 exactly when the write position equals the read position minus one, modulo the depth.
- R9: The write position changes only on a `wofs_we` cycle. A new occupancy is used by the next token after it.
- R10: An ACK or timeout with no data packet outstanding has no effect. The read position stays put, and the next token is answered from occupancy rather than as a retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads the policy fields below |
| cfg_cnt_en | input | 1 | NAK counter enable |
| cfg_limit | input | 4 | Consecutive-NAK limit |
| cfg_maxpkt | input | PTR_W | Maximum packet size in buffer entries |
| wofs_we | input | 1 | Loads a new write position |
| wofs_val | input | PTR_W | Published write position |
| tok_in | input | 1 | IN token strobe |
| hs_ack | input | 1 | Host ACK of the last data packet |
| hs_timeout | input | 1 | Last data packet not acknowledged |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 1 | 1 = data packet, 0 = NAK |
| rsp_len | output | PTR_W | Data packet length |
| rd_ptr | output | PTR_W | Current read position |
| buf_full | output | 1 | Buffer full flag for the processor |

## Verification
The response to a token is registered, so it is due exactly one clock after the `tok_in` cycle. The bench raises the token on a falling edge, drops it on the next falling edge, and samples `rsp_valid`, `rsp_data` and `rsp_len` there, half a period after the rising edge that captured them. ACK and write-offset updates take effect at the next rising edge, so `rd_ptr` and `buf_full` are sampled on the falling edge after the strobe. Because the counter advances one token at a time, the NAK-limit tests check every token in the run, not only the last one.

// File: rtl/usb_in_rsp_pkg.sv
package usb_in_rsp_pkg;
   typedef enum logic {
      RSP_NAK  = 1'b0,
      RSP_DATA = 1'b1
   } rsp_kind_e;
endpackage

// File: rtl/usb_in_occ.sv
module usb_in_occ #(
   parameter int PTR_W = 6
) (
   input  logic [PTR_W-1:0] wr_ptr,
   input  logic [PTR_W-1:0] rd_ptr,
   output logic [PTR_W-1:0] occ,
   output logic             full
);
   localparam logic [PTR_W-1:0] OCC_FULL = '1;

   generate
      if (PTR_W < 2) begin : g_bad_width
         $error("usb_in_occ: PTR_W must be at least 2");
      end
   endgenerate

   // modulo depth falls out of the natural wrap of PTR_W bits
   always_comb begin
      occ  = wr_ptr - rd_ptr;
      full = (occ == OCC_FULL);
   end
endmodule

// File: rtl/usb_in_nak_ctr.sv
module usb_in_nak_ctr #(
   parameter int LIM_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   input  logic             clear,
   input  logic [LIM_W-1:0] limit,
   output logic             over
);
   localparam int              CNT_W   = LIM_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;

   generate
      if (LIM_W < 1) begin : g_bad_lim
         $error("usb_in_nak_ctr: LIM_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                          cnt <= '0;
      else if (clear)                      cnt <= '0;
      else if (bump && (cnt != CNT_MAX))   cnt <= cnt + CNT_ONE;
   end

   assign over = (cnt > {1'b0, limit});
endmodule

// File: rtl/usb_in_nak_responder.sv
module usb_in_nak_responder
   import usb_in_rsp_pkg::*;
#(
   parameter int PTR_W      = 6,
   parameter int LIM_W      = 4,
   parameter int MAXPKT_RST = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_cnt_en,
   input  logic [LIM_W-1:0] cfg_limit,
   input  logic [PTR_W-1:0] cfg_maxpkt,
   input  logic             wofs_we,
   input  logic [PTR_W-1:0] wofs_val,
   input  logic             tok_in,
   input  logic             hs_ack,
   input  logic             hs_timeout,
   output logic             rsp_valid,
   output logic             rsp_data,
   output logic [PTR_W-1:0] rsp_len,
   output logic [PTR_W-1:0] rd_ptr,
   output logic             buf_full
);
   localparam int DEPTH = 1 << PTR_W;

   generate
      if (MAXPKT_RST < 1 || MAXPKT_RST >= DEPTH) begin : g_bad_maxpkt
         $error("usb_in_nak_responder: MAXPKT_RST must lie in 1..DEPTH-1");
      end
   endgenerate

   logic [PTR_W-1:0] wr_q;
   logic [PTR_W-1:0] maxpkt_q;
   logic [LIM_W-1:0] limit_q;
   logic             cnt_en_q;
   logic             pend_q;
   logic             retry_q;
   logic [PTR_W-1:0] pend_len_q;
   logic [PTR_W-1:0] occ;
   logic             over;

   rsp_kind_e        kind;
   logic [PTR_W-1:0] len_sel;
   logic             nak_bump;
   logic             ack_hit;
   logic             tmo_hit;

   usb_in_occ #(.PTR_W(PTR_W)) u_occ (
      .wr_ptr (wr_q),
      .rd_ptr (rd_ptr),
      .occ    (occ),
      .full   (buf_full)
   );

   assign ack_hit  = hs_ack && pend_q;
   assign tmo_hit  = hs_timeout && pend_q && !hs_ack;
   assign nak_bump = tok_in && (kind == RSP_NAK) && cnt_en_q;

   usb_in_nak_ctr #(.LIM_W(LIM_W)) u_nak (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (nak_bump),
      .clear (ack_hit),
      .limit (limit_q),
      .over  (over)
   );

   // response choice: retry, then full packet, then forced short, else NAK
   always_comb begin
      kind    = RSP_NAK;
      len_sel = '0;
      if (retry_q) begin
         kind    = RSP_DATA;
         len_sel = pend_len_q;
      end else if (occ >= maxpkt_q) begin
         kind    = RSP_DATA;
         len_sel = maxpkt_q;
      end else if (cnt_en_q && over) begin
         kind    = RSP_DATA;
         len_sel = occ;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         maxpkt_q <= PTR_W'(MAXPKT_RST);
         limit_q  <= '0;
         cnt_en_q <= 1'b0;
      end else if (cfg_we) begin
         maxpkt_q <= cfg_maxpkt;
         limit_q  <= cfg_limit;
         cnt_en_q <= cfg_cnt_en;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       wr_q <= '0;
      else if (wofs_we) wr_q <= wofs_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_data   <= 1'b0;
         rsp_len    <= '0;
         rd_ptr     <= '0;
         pend_q     <= 1'b0;
         retry_q    <= 1'b0;
         pend_len_q <= '0;
      end else begin
         rsp_valid <= tok_in;
         if (tok_in) begin
            rsp_data <= (kind == RSP_DATA);
            rsp_len  <= (kind == RSP_DATA) ? len_sel : '0;
            if (kind == RSP_DATA) begin
               pend_q     <= 1'b1;
               retry_q    <= 1'b0;
               pend_len_q <= len_sel;
            end
         end else if (ack_hit) begin
            rd_ptr  <= rd_ptr + pend_len_q;
            pend_q  <= 1'b0;
            retry_q <= 1'b0;
         end else if (tmo_hit) begin
            pend_q  <= 1'b0;
            retry_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/usb_in_nak_responder_chk.sv
module usb_in_nak_responder_chk #(
   parameter int PTR_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tok_in,
   input logic             hs_ack,
   input logic             rsp_valid,
   input logic             rsp_data,
   input logic [PTR_W-1:0] rsp_len,
   input logic [PTR_W-1:0] rd_ptr,
   input logic             buf_full,
   input logic [PTR_W-1:0] wr_q,
   input logic [PTR_W-1:0] occ,
   input logic [PTR_W-1:0] maxpkt_q,
   input logic             cnt_en_q,
   input logic             retry_q
);
   localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

   AST_RSP_AFTER_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(tok_in)); // R2

   AST_FULL_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_in && !retry_q && occ >= maxpkt_q) |=> (rsp_data && rsp_len == $past(maxpkt_q))); // R2

   AST_NAK_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_in && !retry_q && !cnt_en_q && occ < maxpkt_q) |=> !rsp_data); // R3

   AST_SHORT_IS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_in && !retry_q && occ < maxpkt_q) |=> (!rsp_data || rsp_len == $past(occ))); // R4

   AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(hs_ack) |-> $stable(rd_ptr)); // R6

   AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full |-> ((wr_q + ONE) == rd_ptr)); // R8
endmodule

bind usb_in_nak_responder usb_in_nak_responder_chk #(.PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tok_in    (tok_in),
   .hs_ack    (hs_ack),
   .rsp_valid (rsp_valid),
   .rsp_data  (rsp_data),
   .rsp_len   (rsp_len),
   .rd_ptr    (rd_ptr),
   .buf_full  (buf_full),
   .wr_q      (wr_q),
   .occ       (occ),
   .maxpkt_q  (maxpkt_q),
   .cnt_en_q  (cnt_en_q),
   .retry_q   (retry_q)
);

// File: tb/usb_in_nak_responder_bench.sv
module usb_in_nak_responder_bench;
   localparam int PTR_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic             cfg_cnt_en = 1'b0;
   logic [3:0]       cfg_limit = '0;
   logic [PTR_W-1:0] cfg_maxpkt = '0;
   logic             wofs_we = 1'b0;
   logic [PTR_W-1:0] wofs_val = '0;
   logic             tok_in = 1'b0;
   logic             hs_ack = 1'b0;
   logic             hs_timeout = 1'b0;
   logic             rsp_valid, rsp_data, buf_full;
   logic [PTR_W-1:0] rsp_len, rd_ptr;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   usb_in_nak_responder u_usb_in_nak_responder (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cnt_en(cfg_cnt_en),
      .cfg_limit(cfg_limit), .cfg_maxpkt(cfg_maxpkt), .wofs_we(wofs_we),
      .wofs_val(wofs_val), .tok_in(tok_in), .hs_ack(hs_ack),
      .hs_timeout(hs_timeout), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_len(rsp_len), .rd_ptr(rd_ptr), .buf_full(buf_full)
   );

   typedef struct packed {
      logic [5:0] wr;
      logic [5:0] mp;
      logic       dat;
      logic [5:0] len;
      logic [5:0] rd;
   } vec_t;

   // counter disabled: full packets or NAK, ACK after every data packet
   localparam vec_t VEC [7] = '{
      '{wr: 6'd8,  mp: 6'd16, dat: 1'b0, len: 6'd0,  rd: 6'd0},
      '{wr: 6'd20, mp: 6'd16, dat: 1'b1, len: 6'd16, rd: 6'd16},
      '{wr: 6'd20, mp: 6'd4,  dat: 1'b1, len: 6'd4,  rd: 6'd20},
      '{wr: 6'd20, mp: 6'd4,  dat: 1'b0, len: 6'd0,  rd: 6'd20},
      '{wr: 6'd63, mp: 6'd32, dat: 1'b1, len: 6'd32, rd: 6'd52},
      '{wr: 6'd3,  mp: 6'd10, dat: 1'b1, len: 6'd10, rd: 6'd62},
      '{wr: 6'd3,  mp: 6'd10, dat: 1'b0, len: 6'd0,  rd: 6'd62}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cfg(input logic en, input logic [3:0] lim, input logic [5:0] mp);
      @(negedge clk);
      cfg_we = 1'b1; cfg_cnt_en = en; cfg_limit = lim; cfg_maxpkt = mp;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wofs(input logic [5:0] v);
      @(negedge clk);
      wofs_we = 1'b1; wofs_val = v;
      @(negedge clk);
      wofs_we = 1'b0;
   endtask

   task automatic token(input string req, input logic exp_dat, input int exp_len);
      @(negedge clk);
      tok_in = 1'b1;
      @(negedge clk);
      tok_in = 1'b0;
      check({req, " valid"}, int'(rsp_valid), 1);
      check({req, " data"}, int'(rsp_data), int'(exp_dat));
      if (exp_dat) check({req, " len"}, int'(rsp_len), exp_len);
   endtask

   task automatic ack();
      @(negedge clk);
      hs_ack = 1'b1;
      @(negedge clk);
      hs_ack = 1'b0;
   endtask

   task automatic tmo();
      @(negedge clk);
      hs_timeout = 1'b1;
      @(negedge clk);
      hs_timeout = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 rd_ptr", int'(rd_ptr), 0);
      check("R1 rsp_valid", int'(rsp_valid), 0);
      check("R1 buf_full", int'(buf_full), 0);

      // R2 / R3 table walk, counter disabled
      for (int i = 0; i < 7; i++) begin
         cfg(1'b0, 4'd0, VEC[i].mp);
         wofs(VEC[i].wr);
         token(VEC[i].dat ? "R2 table" : "R3 table", VEC[i].dat, int'(VEC[i].len));
         if (VEC[i].dat) ack();
         @(negedge clk);
         check("R6 table rd_ptr", int'(rd_ptr), int'(VEC[i].rd));
      end

      // R4: limit 2, occupancy 5 < 10 -> three NAKs then short packet of 5
      cfg(1'b1, 4'd2, 6'd10);
      for (int k = 0; k < 3; k++) token("R4 nak run", 1'b0, 0);
      token("R4 short", 1'b1, 5);

      // R6: timeout keeps rd_ptr, resend same length despite new data
      tmo();
      @(negedge clk);
      check("R6 rd after timeout", int'(rd_ptr), 62);
      wofs(6'd6);
      token("R6 retry", 1'b1, 5);
      ack();
      @(negedge clk);
      check("R6 rd after ack wrap", int'(rd_ptr), 3);

      // R5: counter cleared by ACK, occupancy 3 -> three NAKs again
      for (int k = 0; k < 3; k++) token("R5 nak run", 1'b0, 0);
      token("R5 short", 1'b1, 3);
      ack();

      // R7: empty buffer, limit 0 -> one NAK then zero-length packet
      cfg(1'b1, 4'd0, 6'd10);
      token("R7 nak", 1'b0, 0);
      token("R7 zero len", 1'b1, 0);
      ack();
      @(negedge clk);
      check("R7 rd unchanged", int'(rd_ptr), 6);

      // R10: stray handshakes ignored; counter was cleared, so NAK not retry
      ack();
      tmo();
      @(negedge clk);
      check("R10 rd unchanged", int'(rd_ptr), 6);
      token("R10 no retry", 1'b0, 0);

      // R8: full when write is one behind read
      wofs(6'd5);
      @(negedge clk);
      check("R8 full", int'(buf_full), 1);
      wofs(6'd4);
      @(negedge clk);
      check("R8 not full", int'(buf_full), 0);

      // R3: counter disabled, occupancy 62 < 63 -> NAK forever
      cfg(1'b0, 4'd0, 6'd63);
      for (int k = 0; k < 20; k++) token("R3 long nak", 1'b0, 0);

      // R9: new write offset gives occupancy 63 -> full packet
      wofs(6'd5);
      token("R9 after write", 1'b1, 63);
      finish_run();
   end
endmodule